// File: doc/BRIEF.md
# Configurable Event Counter with Status Output

The block counts events on an asynchronous input line and presents a selectable status signal on a single pad. An 8-bit counter moves one step for every asserted-going edge of the event input, after that input has been brought into the system clock domain and corrected for its programmed polarity. The counter can run upward or downward. In downward mode it can also stop at zero.

A 10-bit control word sets every option. The word is shifted in one bit at a time while a shift strobe is high, with the least significant bit first. It does not change the block's behaviour until an update strobe copies the shift stage into the working register. This follows the usual test-port pattern of a data-register shift followed by an update. The TAP state machine is not part of this block: it supplies the shift, update and capture strobes.

The status pad can show one of four sources: a fixed inactive level, a latched instruction-error flag, the counter's terminal-count condition, or the synchronised event input. The pad's polarity, its drive style (open-drain or 3-state) and its enable are each programmable. The error flag can also be masked on its own.

Top module: `event_counter_status`

## Requirements
- R1: Synchronous reset clears the control register, the shift stage, the counter and the error latch to zero. As a result, the counter is set to count up and the status output enable `stat_oe` is low.
- R2: While `cfg_shift` is high, `cfg_sin` enters the shift stage at bit 9 and moves toward bit 0, so after 10 shifts the first bit sent sits in bit 0. The control register changes only in a cycle where `cfg_update` is high. Shifting alone has no effect on counting or on the pad. Control bit positions: 9 direction, 8 hold-at-zero, 7 pad polarity, 6:5 source, 4 error mask, 3 drive style, 2 pad enable, 1 input polarity, 0 spare.
- R3: With bit 9 = 0, each asserted-going event edge adds one to `count_o`, and 255 wraps to 0.
- R4: With bit 9 = 1 and bit 8 = 0, each event edge subtracts one, and 0 wraps to 255.
- R5: With bits 9 and 8 both 1, a count of 0 stays at 0 and further edges are ignored. In count-up mode, bit 8 has no effect.
- R6: Bit 1 = 1 treats a high event input as asserted. Bit 1 = 0 treats a low input as asserted, so that a rising raw input is not counted.
- R7: With source bits 6:5 = 00, the pad sits at its inactive level. That level is high when bit 7 = 0 (active-low) and low when bit 7 = 1 (active-high).
- R8: With source 10, the pad is active when the count is 0 in down mode or 255 in up mode.
- R9: With source 01, the pad shows an error latch. The latch loads `err_in` only when `err_strobe` is high, which marks the falling test-clock edge in the Pause-IR state. Bit 4 = 1 forces the pad inactive.
- R10: With source 11, the pad follows the synchronised, polarity-corrected event input.
- R11: When bit 2 = 0, `stat_oe` is 0. When bit 2 = 1 and bit 3 = 1 (3-state), `stat_oe` is 1 and `stat_o` carries the level. When bit 2 = 1 and bit 3 = 0 (open-drain), `stat_o` is 0 and `stat_oe` is high only while the level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_shift | input | 1 | Shift strobe for the control shift stage |
| cfg_sin | input | 1 | Serial control data in |
| cfg_update | input | 1 | Update strobe, copies shift stage into control register |
| cfg_sout | output | 1 | Serial data out (bit 0 of shift stage) |
| err_in | input | 1 | Instruction-error flag from the test controller |
| err_strobe | input | 1 | Capture strobe for the error latch |
| evt_in | input | 1 | Asynchronous event input |
| count_o | output | 8 | Current counter value |
| stat_o | output | 1 | Status pad data |
| stat_oe | output | 1 | Status pad output enable |

## Verification
The hardest condition to reach is the up-mode terminal count at 255, because it needs a long run of event pulses. After that run the bench also has to confirm the wrap to 0 and the switch into down mode with hold-at-zero. To get there, the bench drives 252 synchronised pulses from a count of 3, then reprograms the word to walk the counter through zero in both hold settings. Another delicate case is a polarity change while the input sits at its newly asserted level. The bench reprograms polarity while the input is stable and only then moves the input, and it confirms that the count does not move.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int CTL_W = 10;

    typedef enum logic [1:0] {
        SRC_IDLE   = 2'b00,
        SRC_ERROR  = 2'b01,
        SRC_TERM   = 2'b10,
        SRC_FOLLOW = 2'b11
    } stat_src_e;

    typedef struct packed {
        logic      dir_down;
        logic      hold_zero;
        logic      pad_hi;
        stat_src_e src;
        logic      err_mask;
        logic      tristate;
        logic      pad_en;
        logic      in_hi;
        logic      spare;
    } ctl_t;

    function automatic logic term_hit(input logic [7:0] c, input logic down);
        return down ? (c == 8'h00) : (c == 8'hFF);
    endfunction

    function automatic logic pol_apply(input logic v, input logic hi);
        return hi ? v : ~v;
    endfunction

endpackage

// File: rtl/evc_cfg_reg.sv
module evc_cfg_reg
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic shift_i,
    input  logic sin_i,
    input  logic update_i,
    output logic sout_o,
    output ctl_t ctl_o
);

    logic [CTL_W-1:0] stage_q;
    ctl_t             ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            ctl_q   <= '0;
        end else begin
            if (shift_i)
                stage_q <= {sin_i, stage_q[CTL_W-1:1]};
            if (update_i)
                ctl_q <= ctl_t'(stage_q);
        end
    end

    assign sout_o = stage_q[0];
    assign ctl_o  = ctl_q;

    AST_CTL_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !update_i |=> $stable(ctl_q)); // R2

endmodule

// File: rtl/evc_event_cnt.sv
module evc_event_cnt
    import evc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             in_hi,
    input  logic             dir_down,
    input  logic             hold_zero,
    output logic [CNT_W-1:0] count_o,
    output logic             evt_level_o
);

    localparam int CHAIN = SYNC_N + 1;

    logic [CHAIN-1:0] chain_q;
    logic [CNT_W-1:0] cnt_q;
    logic             now_lvl, prev_lvl, step, at_zero, frozen;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN-2:0], evt_i};
    end

    assign now_lvl  = pol_apply(chain_q[SYNC_N-1], in_hi);
    assign prev_lvl = pol_apply(chain_q[SYNC_N], in_hi);
    assign step     = now_lvl & ~prev_lvl;
    assign at_zero  = (cnt_q == '0);
    assign frozen   = dir_down & hold_zero & at_zero;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (step && !frozen)
            cnt_q <= dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end

    assign count_o     = cnt_q;
    assign evt_level_o = now_lvl;

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        step && !dir_down |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        step && dir_down && !(hold_zero && at_zero) |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1)); // R4
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        step && dir_down && hold_zero && at_zero |=> cnt_q == '0); // R5
    AST_NO_EDGE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/evc_stat_drv.sv
module evc_stat_drv
    import evc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl,
    input  logic             err_i,
    input  logic             err_strobe_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             evt_level_i,
    output logic             pad_o,
    output logic             pad_oe_o
);

    logic err_q, active, level;

    always_ff @(posedge clk) begin
        if (rst)               err_q <= 1'b0;
        else if (err_strobe_i) err_q <= err_i;
    end

    always_comb begin
        unique case (ctl.src)
            SRC_IDLE:   active = 1'b0;
            SRC_ERROR:  active = err_q & ~ctl.err_mask;
            SRC_TERM:   active = term_hit(count_i, ctl.dir_down);
            SRC_FOLLOW: active = evt_level_i;
            default:    active = 1'b0;
        endcase
    end

    assign level = pol_apply(active, ctl.pad_hi);

    always_comb begin
        if (!ctl.pad_en) begin
            pad_oe_o = 1'b0;
            pad_o    = level & ctl.tristate;
        end else if (ctl.tristate) begin
            pad_oe_o = 1'b1;
            pad_o    = level;
        end else begin
            pad_oe_o = ~level;
            pad_o    = 1'b0;
        end
    end

    AST_ERR_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !err_strobe_i |=> $stable(err_q)); // R9
    AST_OD_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
        pad_oe_o && !ctl.tristate |-> !pad_o); // R11
    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !ctl.pad_en |-> !pad_oe_o); // R11

endmodule

// File: rtl/event_counter_status.sv
module event_counter_status
    import evc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift,
    input  logic             cfg_sin,
    input  logic             cfg_update,
    output logic             cfg_sout,
    input  logic             err_in,
    input  logic             err_strobe,
    input  logic             evt_in,
    output logic [CNT_W-1:0] count_o,
    output logic             stat_o,
    output logic             stat_oe
);

    ctl_t ctl;
    logic evt_level;

    evc_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .shift_i(cfg_shift), .sin_i(cfg_sin),
        .update_i(cfg_update), .sout_o(cfg_sout), .ctl_o(ctl)
    );

    evc_event_cnt #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cnt (
        .clk(clk), .rst(rst), .evt_i(evt_in), .in_hi(ctl.in_hi),
        .dir_down(ctl.dir_down), .hold_zero(ctl.hold_zero),
        .count_o(count_o), .evt_level_o(evt_level)
    );

    evc_stat_drv #(.CNT_W(CNT_W)) u_drv (
        .clk(clk), .rst(rst), .ctl(ctl), .err_i(err_in),
        .err_strobe_i(err_strobe), .count_i(count_o),
        .evt_level_i(evt_level), .pad_o(stat_o), .pad_oe_o(stat_oe)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> count_o == '0 && !stat_oe); // R1

endmodule

// File: tb/tb_event_counter_status.sv
module tb_event_counter_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_shift = 1'b0, cfg_sin = 1'b0, cfg_update = 1'b0;
    logic       cfg_sout;
    logic       err_in = 1'b0, err_strobe = 1'b0;
    logic       evt_in = 1'b0;
    logic [7:0] count_o;
    logic       stat_o, stat_oe;

    int total = 0;
    int bad   = 0;
    logic idle_lvl = 1'b0;
    int   mc = 0;

    typedef struct {
        int         kind;   // 0 count, 1 pad+oe, 2 oe only
        logic [7:0] cnt;
        logic       pad;
        logic       oe;
        string      tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    event_counter_status dut (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_sin(cfg_sin),
        .cfg_update(cfg_update), .cfg_sout(cfg_sout), .err_in(err_in),
        .err_strobe(err_strobe), .evt_in(evt_in), .count_o(count_o),
        .stat_o(stat_o), .stat_oe(stat_oe)
    );

    // monitor: pops expectations and compares away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (it.kind == 0 && count_o !== it.cnt) begin
                    bad++;
                    $display("FAIL %s count actual=%0d expected=%0d", it.tag, count_o, it.cnt);
                end else if (it.kind == 1 && (stat_o !== it.pad || stat_oe !== it.oe)) begin
                    bad++;
                    $display("FAIL %s pad actual=%b/%b expected=%b/%b", it.tag, stat_o, stat_oe, it.pad, it.oe);
                end else if (it.kind == 2 && stat_oe !== it.oe) begin
                    bad++;
                    $display("FAIL %s oe actual=%b expected=%b", it.tag, stat_oe, it.oe);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input int kind, input logic [7:0] c, input logic p, input logic oe, input string tag);
        item_t it;
        it.kind = kind; it.cnt = c; it.pad = p; it.oe = oe; it.tag = tag;
        q.push_back(it);
        while (q.size() > 0) @(posedge clk);
        #1;
    endtask

    function automatic logic [9:0] word(input logic down, hold, phi, input logic [1:0] src,
                                        input logic mask, tri3, en, ihi);
        return {down, hold, phi, src, mask, tri3, en, ihi, 1'b0};
    endfunction

    task automatic shift_only(input logic [9:0] w);
        for (int i = 0; i < 10; i++) begin
            cfg_shift = 1'b1; cfg_sin = w[i];
            tick(1);
        end
        cfg_shift = 1'b0;
        tick(1);
    endtask

    task automatic update();
        cfg_update = 1'b1; tick(1);
        cfg_update = 1'b0; tick(1);
    endtask

    task automatic load(input logic [9:0] w);
        shift_only(w);
        update();
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = ~idle_lvl; tick(3);
            evt_in = idle_lvl;  tick(5);
        end
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        tick(3);
        rst = 1'b0;
        tick(1);
        push(0, 8'd0, 1'b0, 1'b0, "R1 reset count");
        push(2, 8'd0, 1'b0, 1'b0, "R1 reset oe");

        // R7 inactive level, both polarities, 3-state enabled
        load(word(0, 0, 0, 2'b00, 0, 1, 1, 1));
        push(1, 8'd0, 1'b1, 1'b1, "R7 idle active-low");
        load(word(0, 0, 1, 2'b00, 0, 1, 1, 1));
        push(1, 8'd0, 1'b0, 1'b1, "R7 idle active-high");

        // R3 count up
        pulse(3);
        push(0, 8'd3, 1'b0, 1'b0, "R3 up three");

        // R2 shift without update has no effect
        shift_only(word(1, 0, 1, 2'b00, 0, 1, 1, 1));
        pulse(1);
        push(0, 8'd4, 1'b0, 1'b0, "R2 no update still up");
        update();
        pulse(1);
        push(0, 8'd3, 1'b0, 1'b0, "R4 R2 down after update");

        // R8 terminal count in up mode
        load(word(0, 0, 1, 2'b10, 0, 1, 1, 1));
        push(1, 8'd0, 1'b0, 1'b1, "R8 not terminal at 3");
        pulse(252);
        push(0, 8'd255, 1'b0, 1'b0, "R3 reach 255");
        push(1, 8'd0, 1'b1, 1'b1, "R8 terminal at 255 up");
        pulse(1);
        push(0, 8'd0, 1'b0, 1'b0, "R3 wrap to 0");
        push(1, 8'd0, 1'b0, 1'b1, "R8 zero not terminal up");

        // R5 hold at zero in down mode
        load(word(1, 1, 1, 2'b10, 0, 1, 1, 1));
        push(1, 8'd0, 1'b1, 1'b1, "R8 terminal at 0 down");
        pulse(2);
        push(0, 8'd0, 1'b0, 1'b0, "R5 held at zero");

        // R5 hold bit ignored when counting up
        load(word(0, 1, 1, 2'b10, 0, 1, 1, 1));
        pulse(1);
        push(0, 8'd1, 1'b0, 1'b0, "R5 hold no effect up");

        // R4 down through zero with hold clear
        load(word(1, 0, 1, 2'b10, 0, 1, 1, 1));
        pulse(2);
        push(0, 8'd255, 1'b0, 1'b0, "R4 wrap to 255");

        // R6 input polarity: active-low
        load(word(0, 0, 1, 2'b00, 0, 1, 1, 0));
        idle_lvl = 1'b1;
        evt_in = 1'b1;
        tick(6);
        push(0, 8'd255, 1'b0, 1'b0, "R6 rising raw not counted");
        pulse(1);
        push(0, 8'd0, 1'b0, 1'b0, "R6 low pulse counted");

        // R10 follow the event input (active-low input, active-high pad)
        load(word(0, 0, 1, 2'b11, 0, 1, 1, 0));
        evt_in = 1'b0;
        tick(4);
        push(1, 8'd0, 1'b1, 1'b1, "R10 follow asserted");
        evt_in = 1'b1;
        tick(4);
        push(1, 8'd0, 1'b0, 1'b1, "R10 follow released");

        // R9 error latch and mask
        load(word(0, 0, 1, 2'b01, 0, 1, 1, 0));
        err_in = 1'b1;
        tick(2);
        push(1, 8'd0, 1'b0, 1'b1, "R9 no strobe no capture");
        err_strobe = 1'b1; tick(1);
        err_strobe = 1'b0; tick(1);
        push(1, 8'd0, 1'b1, 1'b1, "R9 error shown");
        err_in = 1'b0;
        tick(2);
        push(1, 8'd0, 1'b1, 1'b1, "R9 latch holds");
        load(word(0, 0, 1, 2'b01, 1, 1, 1, 0));
        push(1, 8'd0, 1'b0, 1'b1, "R9 mask");

        // R11 open-drain and disable
        load(word(0, 0, 0, 2'b00, 0, 0, 1, 0));
        push(1, 8'd0, 1'b0, 1'b0, "R11 open-drain high released");
        load(word(0, 0, 1, 2'b00, 0, 0, 1, 0));
        push(1, 8'd0, 1'b0, 1'b1, "R11 open-drain low driven");
        load(word(0, 0, 0, 2'b00, 0, 1, 0, 0));
        push(2, 8'd0, 1'b0, 1'b0, "R11 disabled released");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule